// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

This block is a byte-addressed timer with a 16-bit up-counter and one 16-bit holding pair. The counter advances by one on every clock in which the run-enable input is high. The holding pair is used in one of two ways, chosen by a mode input. In capture mode, a falling edge on an external trigger pin takes a snapshot of the running count into the pair. In auto-reload mode, the pair supplies the value that the counter restarts from after it passes its all-ones state.

A host reads and writes the counter bytes, the holding bytes and a two-flag status byte through a simple byte port, with a write strobe and a combinational read. A roll-over of the counter raises a sticky overflow flag. A trigger edge raises a sticky external flag. Software clears either flag by writing 0 to its status bit.

Widths are parameters. The counter is built from `CNT_BYTES` lanes of `BYTE_W` bits. The address map is derived from the lane count: counter lanes come first, then holding lanes, then the status byte.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every counter and holding byte, both flags and every readable address read as zero.
- R2: With default parameters, address 0 is the counter low byte, 1 the counter high byte, 2 the holding low byte, 3 the holding high byte and 4 the status byte. A write to any of the first four takes effect on the next clock and reads back unchanged.
- R3: The counter increments by exactly one on each clock with `count_en` high, carries from the low byte into the high byte, and holds when `count_en` is low.
- R4: In capture mode (`mode_cap`=1), an increment from FFFFH gives 0000H and sets the overflow flag (status bit 0 and `ovf_flag`).
- R5: In auto-reload mode (`mode_cap`=0), an increment from FFFFH loads the counter from the holding pair {high, low} and sets the overflow flag.
- R6: In capture mode, a 1-to-0 transition on `trig_pin` copies the counter into the holding pair at the third rising clock edge after the first edge that samples the pin low. A 0-to-1 transition copies nothing.
- R7: A 1-to-0 transition on `trig_pin` sets the external flag (status bit 1 and `ext_flag`) in either mode. In auto-reload mode it leaves the holding pair unchanged.
- R8: When a capture and an increment fall on the same clock, the holding pair receives the count from before that increment.
- R9: Both flags stay set until a status write carries 0 in that flag's bit. A 1 in the bit leaves the flag alone, and a hardware set in the same clock wins over a clear.
- R10: A host write to either counter byte takes priority over an increment in the same clock: that increment is dropped and the other byte is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Run enable; counter advances on each clock it is high |
| mode_cap | input | 1 | 1 = capture mode, 0 = auto-reload mode |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 3 | Byte address (width derived from CNT_BYTES) |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external trigger flag |

## Verification
The bench builds the block with its defaults: two 8-bit lanes, a two-flop synchronizer and falling-edge triggering. This gives the three-edge capture latency that the bench predicts cycle by cycle. Because the counter is only 16 bits and can be preloaded through the byte port, the FFFFH roll-over, the reload from an all-ones holding value, and the low-to-high carry are all reached within a few clocks. Those short runs also let the bench place a capture, a status clear or a counter write in exactly the same clock as an increment or an overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic {
      MODE_RELOAD  = 1'b0,
      MODE_CAPTURE = 1'b1
   } tmr_mode_e;

   localparam int unsigned FLAG_OVF  = 0;
   localparam int unsigned FLAG_EXT  = 1;
   localparam int unsigned NUM_FLAGS = 2;

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic evt_o
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              settled;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign settled = sync_q[STAGES-1];

   generate
      if (FALLING) begin : g_fall
         assign evt_o = last_q & ~settled;
      end else begin : g_rise
         assign evt_o = ~last_q & settled;
      end
   endgenerate

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic                     reload_i,
   input  logic [NBYTES-1:0]        wr_be_i,
   input  logic [BYTE_W-1:0]        wdata_i,
   input  logic [BYTE_W*NBYTES-1:0] reload_val_i,
   output logic [BYTE_W*NBYTES-1:0] cnt_o,
   output logic                     ovf_o
);

   localparam int unsigned CNT_W = BYTE_W * NBYTES;

   logic [NBYTES-1:0][BYTE_W-1:0] lane_q;
   logic [CNT_W-1:0]              cnt_flat;
   logic [CNT_W-1:0]              next_val;
   logic                          step;
   logic                          at_max;

   assign cnt_flat = lane_q;
   assign at_max   = &cnt_flat;
   assign step     = en_i && !(|wr_be_i);
   assign ovf_o    = step && at_max;

   always_comb begin
      if (at_max) begin
         next_val = reload_i ? reload_val_i : '0;
      end else begin
         next_val = cnt_flat + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_q[g] <= '0;
            end else if (wr_be_i[g]) begin
               lane_q[g] <= wdata_i;
            end else if (step) begin
               lane_q[g] <= next_val[g*BYTE_W +: BYTE_W];
            end
         end
      end
   endgenerate

   assign cnt_o = cnt_flat;

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_evt_i,
   input  logic [BYTE_W*NBYTES-1:0] cnt_i,
   input  logic [NBYTES-1:0]        wr_be_i,
   input  logic [BYTE_W-1:0]        wdata_i,
   output logic [BYTE_W*NBYTES-1:0] hold_o
);

   logic [NBYTES-1:0][BYTE_W-1:0] lane_q;

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_q[g] <= '0;
            end else if (cap_evt_i) begin
               lane_q[g] <= cnt_i[g*BYTE_W +: BYTE_W];
            end else if (wr_be_i[g]) begin
               lane_q[g] <= wdata_i;
            end
         end
      end
   endgenerate

   assign hold_o = lane_q;

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic                 wr_i,
   input  logic [BYTE_W-1:0]    wdata_i,
   output logic [NUM_FLAGS-1:0] flag_o
);

   generate
      if (BYTE_W < NUM_FLAGS) begin : g_bad_width
         $error("tmr_flags: BYTE_W too narrow for the status byte");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] flag_q;

   generate
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q[f] <= 1'b0;
            end else if (set_i[f]) begin
               flag_q[f] <= 1'b1;
            end else if (wr_i && !wdata_i[f]) begin
               flag_q[f] <= 1'b0;
            end
         end
      end
   endgenerate

   assign flag_o = flag_q;

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned CNT_BYTES    = 2,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          TRIG_FALLING = 1'b1,
   localparam int unsigned CNT_W       = BYTE_W * CNT_BYTES,
   localparam int unsigned STAT_ADDR   = 2 * CNT_BYTES,
   localparam int unsigned ADDR_W      = $clog2(STAT_ADDR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   input  logic              mode_cap,
   input  logic              trig_pin,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic              ovf_flag,
   output logic              ext_flag
);

   generate
      if (CNT_BYTES < 1) begin : g_bad_lanes
         $error("cap_reload_timer: CNT_BYTES must be at least 1");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("cap_reload_timer: BYTE_W must be at least 2");
      end
   endgenerate

   tmr_mode_e            mode;
   logic [CNT_BYTES-1:0] cnt_be;
   logic [CNT_BYTES-1:0] cap_be;
   logic                 stat_wr;
   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     cap_q;
   logic                 trig_evt;
   logic                 cap_evt;
   logic                 ovf_pulse;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flags;

   assign mode = tmr_mode_e'(mode_cap);

   generate
      for (genvar g = 0; g < CNT_BYTES; g++) begin : g_dec
         assign cnt_be[g] = reg_wr && (reg_addr == ADDR_W'(g));
         assign cap_be[g] = reg_wr && (reg_addr == ADDR_W'(CNT_BYTES + g));
      end
   endgenerate

   assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

   tmr_trig_sync #(
      .STAGES  (SYNC_STAGES),
      .FALLING (TRIG_FALLING)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (trig_pin),
      .evt_o (trig_evt)
   );

   assign cap_evt = trig_evt && (mode == MODE_CAPTURE);

   tmr_counter #(
      .BYTE_W (BYTE_W),
      .NBYTES (CNT_BYTES)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (count_en),
      .reload_i     (mode == MODE_RELOAD),
      .wr_be_i      (cnt_be),
      .wdata_i      (reg_wdata),
      .reload_val_i (cap_q),
      .cnt_o        (cnt_q),
      .ovf_o        (ovf_pulse)
   );

   tmr_capture #(
      .BYTE_W (BYTE_W),
      .NBYTES (CNT_BYTES)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_evt_i (cap_evt),
      .cnt_i     (cnt_q),
      .wr_be_i   (cap_be),
      .wdata_i   (reg_wdata),
      .hold_o    (cap_q)
   );

   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_OVF] = ovf_pulse;
      flag_set[FLAG_EXT] = trig_evt;
   end

   tmr_flags #(
      .BYTE_W (BYTE_W)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (flag_set),
      .wr_i    (stat_wr),
      .wdata_i (reg_wdata),
      .flag_o  (flags)
   );

   assign ovf_flag = flags[FLAG_OVF];
   assign ext_flag = flags[FLAG_EXT];

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < int'(CNT_BYTES); i++) begin
         if (reg_addr == ADDR_W'(i)) begin
            reg_rdata = cnt_q[i*BYTE_W +: BYTE_W];
         end
         if (reg_addr == ADDR_W'(int'(CNT_BYTES) + i)) begin
            reg_rdata = cap_q[i*BYTE_W +: BYTE_W];
         end
      end
      if (reg_addr == ADDR_W'(STAT_ADDR)) begin
         reg_rdata[NUM_FLAGS-1:0] = flags;
      end
   end

endmodule

// File: rtl/cap_reload_timer_chk.sv
module cap_reload_timer_chk #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned CNT_BYTES = 2,
   parameter int unsigned ADDR_W    = 3,
   localparam int unsigned CNT_W    = BYTE_W * CNT_BYTES,
   localparam int unsigned STAT_ADDR = 2 * CNT_BYTES
) (
   input logic              clk,
   input logic              rst_n,
   input logic              count_en,
   input logic              mode_cap,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [BYTE_W-1:0] reg_wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cap,
   input logic              trig_evt,
   input logic              ovf_flag,
   input logic              ext_flag
);

   logic cnt_wr;
   logic cap_wr;
   logic stat_wr;

   assign cnt_wr  = reg_wr && (reg_addr < ADDR_W'(CNT_BYTES));
   assign cap_wr  = reg_wr && (reg_addr >= ADDR_W'(CNT_BYTES)) && (reg_addr < ADDR_W'(STAT_ADDR));
   assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !cnt_wr) |=> (cnt == $past(cnt))); // R3

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !cnt_wr && !(&cnt)) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R3

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cap && count_en && !cnt_wr && (&cnt)) |=> (cnt == '0 && ovf_flag)); // R4

   AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_cap && count_en && !cnt_wr && (&cnt)) |=> (cnt == $past(cap) && ovf_flag)); // R5

   AST_CAPTURE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_evt && mode_cap) |=> (cap == $past(cnt))); // R8

   AST_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |=> ext_flag); // R7

   AST_RELOAD_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_evt && !mode_cap && !cap_wr) |=> (cap == $past(cap))); // R7

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !(stat_wr && !reg_wdata[0])) |=> ovf_flag); // R9

   AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_flag && !(stat_wr && !reg_wdata[1])) |=> ext_flag); // R9

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0) |=> (cnt[BYTE_W-1:0] == $past(reg_wdata))); // R10

endmodule

bind cap_reload_timer cap_reload_timer_chk #(
   .BYTE_W    (BYTE_W),
   .CNT_BYTES (CNT_BYTES),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .count_en  (count_en),
   .mode_cap  (mode_cap),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .cnt       (cnt_q),
   .cap       (cap_q),
   .trig_evt  (trig_evt),
   .ovf_flag  (ovf_flag),
   .ext_flag  (ext_flag)
);

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       count_en = 1'b0;
   logic       mode_cap = 1'b1;
   logic       trig_pin = 1'b1;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ovf_flag;
   logic       ext_flag;

   int vectors = 0;
   int fails   = 0;

   always #(CLK_P/2) clk = ~clk;

   cap_reload_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (count_en),
      .mode_cap  (mode_cap),
      .trig_pin  (trig_pin),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ovf_flag  (ovf_flag),
      .ext_flag  (ext_flag)
   );

   typedef struct packed {
      logic        mode;
      logic [15:0] start;
      logic [15:0] hold;
      logic [7:0]  n;
      logic [15:0] exp_cnt;
      logic        exp_ovf;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 16'h0000, 16'h0000, 8'd5, 16'h0005, 1'b0},
      '{1'b1, 16'hFFFE, 16'h0000, 8'd3, 16'h0001, 1'b1},
      '{1'b0, 16'hFFFD, 16'h1234, 8'd4, 16'h1235, 1'b1},
      '{1'b0, 16'h00FF, 16'hAAAA, 8'd1, 16'h0100, 1'b0},
      '{1'b0, 16'hFFFF, 16'hFFF0, 8'd1, 16'hFFF0, 1'b1},
      '{1'b1, 16'h12FF, 16'h0000, 8'd0, 16'h12FF, 1'b0},
      '{1'b0, 16'hFFFF, 16'hFFFF, 8'd2, 16'hFFFF, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wr16(input logic [2:0] base, input logic [15:0] v);
      wr(base, v[7:0]);
      wr(3'(base + 3'd1), v[15:8]);
   endtask

   task automatic rd16(input logic [2:0] base, output logic [15:0] v);
      @(negedge clk);
      reg_addr = base;
      #1 v[7:0] = reg_rdata;
      reg_addr = 3'(base + 3'd1);
      #1 v[15:8] = reg_rdata;
   endtask

   task automatic run(input int n);
      @(negedge clk);
      count_en = 1'b1;
      repeat (n) @(negedge clk);
      count_en = 1'b0;
   endtask

   task automatic settle_pin_high();
      @(negedge clk);
      trig_pin = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [15:0] c;
      logic [7:0]  b;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         @(negedge clk);
         reg_addr = 3'(a);
         #1 chk($sformatf("R1 addr %0d after reset", a), reg_rdata, 0);
      end
      chk("R1 ovf_flag after reset", ovf_flag, 0);
      chk("R1 ext_flag after reset", ext_flag, 0);

      // R2 byte access
      wr16(3'd2, 16'hC35A);
      rd16(3'd2, v);
      chk("R2 holding pair readback", v, 16'hC35A);
      wr16(3'd0, 16'h9E01);
      rd16(3'd0, v);
      chk("R2 counter readback", v, 16'h9E01);

      // R3 R4 R5 table of counting runs
      for (int i = 0; i < NV; i++) begin
         mode_cap = VEC[i].mode;
         wr(3'd4, 8'h00);
         wr16(3'd0, VEC[i].start);
         wr16(3'd2, VEC[i].hold);
         run(int'(VEC[i].n));
         rd16(3'd0, v);
         chk($sformatf("R3/R4/R5 vector %0d count", i), v, VEC[i].exp_cnt);
         chk($sformatf("R4/R5 vector %0d ovf_flag", i), ovf_flag, VEC[i].exp_ovf);
         @(negedge clk);
         reg_addr = 3'd4;
         #1 chk($sformatf("R4 vector %0d status bit0", i), reg_rdata[0], VEC[i].exp_ovf);
      end

      // R6 capture latency, counter idle
      mode_cap = 1'b1;
      wr(3'd4, 8'h00);
      wr16(3'd0, 16'hBEEF);
      wr16(3'd2, 16'h0000);
      @(negedge clk);
      trig_pin = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      reg_addr = 3'd2;
      #1 chk("R6 no capture before third edge", reg_rdata, 8'h00);
      @(posedge clk);
      rd16(3'd2, v);
      chk("R6 capture at third edge", v, 16'hBEEF);
      chk("R7 ext_flag set by falling edge", ext_flag, 1);

      // R6 rising edge ignored
      wr(3'd4, 8'h00);
      wr16(3'd0, 16'h1111);
      settle_pin_high();
      rd16(3'd2, v);
      chk("R6 rising edge no capture", v, 16'hBEEF);
      chk("R7 rising edge leaves ext_flag", ext_flag, 0);

      // R8 capture while counting
      wr16(3'd0, 16'h0100);
      @(negedge clk);
      count_en = 1'b1;
      repeat (4) @(negedge clk);
      reg_addr = 3'd0;
      #1 c[7:0] = reg_rdata;
      reg_addr = 3'd1;
      #1 c[15:8] = reg_rdata;
      trig_pin = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      count_en = 1'b0;
      rd16(3'd2, v);
      chk("R8 capture takes pre-increment count", v, 16'(c + 16'd2));
      chk("R8 count start as predicted", c, 16'h0104);

      // R7 reload mode trigger: flag only
      settle_pin_high();
      mode_cap = 1'b0;
      wr(3'd4, 8'h00);
      wr16(3'd2, 16'h7777);
      wr16(3'd0, 16'h0003);
      @(negedge clk);
      trig_pin = 1'b0;
      repeat (6) @(negedge clk);
      rd16(3'd2, v);
      chk("R7 reload mode holding unchanged", v, 16'h7777);
      chk("R7 reload mode ext_flag", ext_flag, 1);

      // R9 sticky flags and selective clear
      wr16(3'd0, 16'hFFFF);
      run(1);
      repeat (3) @(negedge clk);
      chk("R9 ovf_flag sticky", ovf_flag, 1);
      chk("R9 ext_flag sticky", ext_flag, 1);
      wr(3'd4, 8'h02);
      chk("R9 bit0 zero clears ovf", ovf_flag, 0);
      chk("R9 bit1 one keeps ext", ext_flag, 1);
      wr(3'd4, 8'h01);
      chk("R9 bit1 zero clears ext", ext_flag, 0);

      // R9 set wins over clear
      mode_cap = 1'b1;
      wr16(3'd0, 16'hFFFF);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = 3'd4;
      reg_wdata = 8'h00;
      count_en  = 1'b1;
      @(negedge clk);
      reg_wr   = 1'b0;
      count_en = 1'b0;
      chk("R9 overflow set beats clear", ovf_flag, 1);
      rd16(3'd0, v);
      chk("R4 wrap during status write", v, 16'h0000);

      // R10 counter write beats increment
      wr16(3'd0, 16'h0010);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = 3'd0;
      reg_wdata = 8'h80;
      count_en  = 1'b1;
      @(negedge clk);
      reg_wr   = 1'b0;
      count_en = 1'b0;
      rd16(3'd0, v);
      chk("R10 write wins, increment dropped", v, 16'h0080);

      // R1 reset again clears everything
      wr16(3'd2, 16'h5555);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd16(3'd2, v);
      chk("R1 holding pair after second reset", v, 16'h0000);
      @(negedge clk);
      reg_addr = 3'd4;
      #1 b = reg_rdata;
      chk("R1 status after second reset", b, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule